// File: doc/BRIEF.md
# Per-Source Bit Frame Reassembler

On a bit-interleaved shared line, every node owns one recurring slot and sends a single bit in each of its turns. A receiving node therefore sees several frames arrive at the same time, one bit at a time and mixed together. This block takes each decoded line bit together with the index of the slot it came from. It sends that bit to a private assembly lane for the owning source, so frames from different senders never mix, however their bits alternate.

Every remote source has its own lane. A lane holds a shift register, a bit counter that counts to eight, a frame phase and a one-byte hand-off buffer. A lane ignores idle 1 bits until it sees a 0, which marks the start of a frame. The first character collected after that is the destination address, which the lane compares with this node's address and with the broadcast code. Payload characters of an accepted frame go to the host through a valid/acknowledge pair. Payload of a frame meant for another node is consumed and dropped. Slot timing and line decoding are done upstream. The slot that this node transmits in has no lane.

Top module: `slot_frame_reassembler`

## Requirements
- R1: After reset, every bit of rx_valid, rx_ovf and rx_data is 0.
- R2: While a lane waits for a frame, a strobed 1 bit changes nothing. A strobed 0 bit is the start marker, and the next bit of that slot is bit 0 of the destination character.
- R3: Characters are 8 bits, least significant bit first. Each slot index feeds only its own lane, so bits of different sources can be interleaved in any order without affecting one another.
- R4: A frame whose destination character equals node_addr is accepted. Each of its PAY_BYTES payload characters appears on that slot's 8-bit field of rx_data, with its rx_valid bit set, from the cycle after its last bit is strobed.
- R5: A frame whose destination character is 0xFF is accepted in the same way as in R4.
- R6: A frame with any other destination never raises rx_valid. Its PAY_BYTES payload characters are still consumed, and after them the lane again waits for a start marker.
- R7: A 1 on rd_ack for a slot clears that slot's rx_valid and rx_ovf on the next clock edge.
- R8: If an accepted payload character completes while the slot's buffer still holds an unacknowledged byte, rx_ovf for that slot is set, the new character is dropped, and rx_data keeps the old byte.
- R9: Strobes carrying slot index OWN_SLOT change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | A decoded bit is present this cycle |
| slot_idx | input | $clog2(N_SLOTS) | Slot that carried the bit |
| rx_bit | input | 1 | Decoded line bit |
| node_addr | input | 8 | Address of this node |
| rd_ack | input | N_SLOTS | Host read acknowledge, one per slot |
| rx_data | output | N_SLOTS*8 | Delivered byte per slot, slot k in bits 8k+7..8k |
| rx_valid | output | N_SLOTS | Delivered byte waiting to be read, per slot |
| rx_ovf | output | N_SLOTS | Byte lost because the buffer was full, per slot |

## Verification
Properties are checked on every cycle. A 1 bit seen while waiting leaves the lane waiting with its counter at zero. An overflow keeps the stored byte. A rejected frame never touches the buffer. An acknowledge empties the buffer. Own-slot strobes leave the outputs unchanged. At most one slot can gain a byte per cycle. Only the scenarios can show full behaviour: correct byte values after random interleaving of three sources, acceptance decided by address and broadcast, and a lane returning to the waiting state once a foreign frame has been consumed. These are checked against frames that the bench builds and filters itself.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam logic [CHAR_W-1:0] BCAST_ADDR = 8'hFF;

  typedef enum logic [1:0] {
    LN_WAIT = 2'd0,
    LN_DEST = 2'd1,
    LN_BODY = 2'd2
  } lane_phase_e;
endpackage

// File: rtl/sfr_addr_filter.sv
module sfr_addr_filter
  import sfr_pkg::*;
(
  input  logic [CHAR_W-1:0] dest,
  input  logic [CHAR_W-1:0] self_addr,
  output logic              hit
);
  always_comb begin
    hit = (dest == self_addr) || (dest == BCAST_ADDR);
  end
endmodule

// File: rtl/sfr_lane.sv
module sfr_lane
  import sfr_pkg::*;
#(
  parameter int unsigned PAY_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [CHAR_W-1:0] self_addr,
  input  logic              rd_ack,
  output logic [CHAR_W-1:0] data_o,
  output logic              valid_o,
  output logic              ovf_o
);
  localparam int unsigned PB_W = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1;
  localparam logic [PB_W-1:0] LAST_BYTE = PB_W'(PAY_BYTES - 1);
  localparam int unsigned BC_W = $clog2(CHAR_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(CHAR_W - 1);

  lane_phase_e       ph_q, ph_n;
  logic [BC_W-1:0]   bc_q, bc_n;
  logic [PB_W-1:0]   by_q, by_n;
  logic [CHAR_W-1:0] sh_q, sh_n;
  logic              acc_q, acc_n;
  logic [CHAR_W-1:0] dat_q, dat_n;
  logic              vld_q, vld_n;
  logic              ovf_q, ovf_n;
  logic [CHAR_W-1:0] char_val;
  logic              addr_hit;

  assign char_val = {bit_in, sh_q[CHAR_W-1:1]};

  sfr_addr_filter u_filter (
    .dest      (char_val),
    .self_addr (self_addr),
    .hit       (addr_hit)
  );

  always_comb begin
    ph_n  = ph_q;
    bc_n  = bc_q;
    by_n  = by_q;
    sh_n  = sh_q;
    acc_n = acc_q;
    dat_n = dat_q;
    vld_n = vld_q & ~rd_ack;
    ovf_n = ovf_q & ~rd_ack;
    if (bit_en) begin
      if (ph_q == LN_WAIT) begin
        if (!bit_in) begin
          ph_n = LN_DEST;
          bc_n = '0;
        end
      end else begin
        sh_n = char_val;
        bc_n = bc_q + 1'b1;
        if (bc_q == LAST_BIT) begin
          if (ph_q == LN_DEST) begin
            acc_n = addr_hit;
            ph_n  = LN_BODY;
            by_n  = '0;
          end else begin
            if (acc_q) begin
              if (vld_n) begin
                ovf_n = 1'b1;
              end else begin
                dat_n = char_val;
                vld_n = 1'b1;
              end
            end
            if (by_q == LAST_BYTE) begin
              ph_n = LN_WAIT;
            end else begin
              by_n = by_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= LN_WAIT;
      bc_q  <= '0;
      by_q  <= '0;
      sh_q  <= '0;
      acc_q <= 1'b0;
      dat_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      bc_q  <= bc_n;
      by_q  <= by_n;
      sh_q  <= sh_n;
      acc_q <= acc_n;
      dat_q <= dat_n;
      vld_q <= vld_n;
      ovf_q <= ovf_n;
    end
  end

  assign data_o  = dat_q;
  assign valid_o = vld_q;
  assign ovf_o   = ovf_q;

  // R2: a 1 bit while waiting keeps the lane waiting with a clear counter
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == LN_WAIT && bit_en && bit_in) |=> (ph_q == LN_WAIT && bc_q == '0));

  // R8: a full buffer keeps its byte and flags the loss
  assert_ovf_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ph_q == LN_BODY && bc_q == LAST_BIT && acc_q && vld_q && !rd_ack)
      |=> (ovf_q && vld_q && $stable(dat_q)));

  // R6: payload of a rejected frame never reaches the buffer
  assert_reject_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ph_q == LN_BODY && !acc_q) |=> $stable(dat_q));

  // R7: an acknowledge without a completing character empties the buffer
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !(bit_en && ph_q == LN_BODY && bc_q == LAST_BIT)) |=> (!vld_q && !ovf_q));
endmodule

// File: rtl/slot_frame_reassembler.sv
module slot_frame_reassembler
  import sfr_pkg::*;
#(
  parameter int unsigned N_SLOTS   = 4,
  parameter int unsigned OWN_SLOT  = 0,
  parameter int unsigned PAY_BYTES = 2,
  localparam int unsigned SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_en,
  input  logic [SLOT_W-1:0]          slot_idx,
  input  logic                       rx_bit,
  input  logic [CHAR_W-1:0]          node_addr,
  input  logic [N_SLOTS-1:0]         rd_ack,
  output logic [N_SLOTS*CHAR_W-1:0]  rx_data,
  output logic [N_SLOTS-1:0]         rx_valid,
  output logic [N_SLOTS-1:0]         rx_ovf
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    if (g == OWN_SLOT) begin : g_own
      logic unused_ack;
      assign unused_ack = rd_ack[g];
      assign rx_data[g*CHAR_W +: CHAR_W] = '0;
      assign rx_valid[g] = 1'b0;
      assign rx_ovf[g]   = 1'b0;
    end else begin : g_remote
      logic lane_en;
      assign lane_en = rx_en && (slot_idx == SLOT_W'(g));
      sfr_lane #(.PAY_BYTES(PAY_BYTES)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (lane_en),
        .bit_in    (rx_bit),
        .self_addr (node_addr),
        .rd_ack    (rd_ack[g]),
        .data_o    (rx_data[g*CHAR_W +: CHAR_W]),
        .valid_o   (rx_valid[g]),
        .ovf_o     (rx_ovf[g])
      );
    end
  end

  // R9: own-slot strobes leave every output as it was
  assert_own_slot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && slot_idx == SLOT_W'(OWN_SLOT) && rd_ack == '0)
      |=> ($stable(rx_valid) && $stable(rx_ovf) && $stable(rx_data)));

  // R3: one strobe feeds one lane, so at most one slot gains a byte per cycle
  assert_single_delivery_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_valid & ~$past(rx_valid)) <= 1);
endmodule

// File: tb/slot_frame_reassembler_tb_top.sv
module slot_frame_reassembler_tb_top;
  localparam int N   = 4;
  localparam int OWN = 0;
  localparam logic [7:0] SELF = 8'h5A;

  logic           clk;
  logic           rst_n;
  logic           rx_en;
  logic [1:0]     slot_idx;
  logic           rx_bit;
  logic [7:0]     node_addr;
  logic [N-1:0]   rd_ack;
  logic [N*8-1:0] rx_data;
  logic [N-1:0]   rx_valid;
  logic [N-1:0]   rx_ovf;

  int checks = 0;
  int errors = 0;
  bit auto_ack = 1'b1;
  logic [N-1:0] man_ack = '0;
  bit  sq[N][$];
  logic [7:0] expq[N][$];

  slot_frame_reassembler #(.N_SLOTS(N), .OWN_SLOT(OWN), .PAY_BYTES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .slot_idx(slot_idx), .rx_bit(rx_bit),
    .node_addr(node_addr), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ovf(rx_ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit accepts(input logic [7:0] dest);
    return (dest == SELF) || (dest == 8'hFF);
  endfunction

  task automatic push_char(input int s, input logic [7:0] c);
    for (int i = 0; i < 8; i++) sq[s].push_back(c[i]);
  endtask

  task automatic queue_frame(input int s, input logic [7:0] dest,
                             input logic [7:0] p0, input logic [7:0] p1, input int idle);
    for (int i = 0; i < idle; i++) sq[s].push_back(1'b1);
    sq[s].push_back(1'b0);
    push_char(s, dest);
    push_char(s, p0);
    push_char(s, p1);
    if (accepts(dest)) begin
      expq[s].push_back(p0);
      expq[s].push_back(p1);
    end
  endtask

  task automatic step(input logic en, input int s, input logic b);
    logic [N-1:0] ack;
    logic [7:0] e;
    @(negedge clk);
    ack = '0;
    if (auto_ack) begin
      for (int k = 0; k < N; k++) begin
        chk(rx_ovf[k] == 1'b0, "R8 no false overflow", rx_ovf[k], 0);
        if (rx_valid[k]) begin
          if (expq[k].size() == 0) begin
            chk(1'b0, "R6 unexpected delivery", rx_data[k*8 +: 8], 0);
          end else begin
            e = expq[k].pop_front();
            chk(rx_data[k*8 +: 8] == e, "R4/R5/R3 payload byte", rx_data[k*8 +: 8], e);
          end
          ack[k] = 1'b1;
        end
      end
      rd_ack = ack;
    end else begin
      rd_ack = man_ack;
    end
    rx_en    = en;
    slot_idx = 2'(s);
    rx_bit   = b;
  endtask

  task automatic run_streams(input bit rand_slot, input string tag);
    int s;
    int rr;
    bit en;
    bit b;
    bit busy;
    rr = 0;
    forever begin
      busy = 1'b0;
      for (int k = 0; k < N; k++) if (sq[k].size() != 0) busy = 1'b1;
      if (!busy) break;
      if (rand_slot) begin
        s  = $urandom_range(0, N - 1);
        en = ($urandom_range(0, 99) < 80);
      end else begin
        s  = rr;
        rr = (rr + 1) % N;
        en = 1'b1;
      end
      if (s == OWN) b = 1'($urandom);
      else if (en && sq[s].size() != 0) b = sq[s].pop_front();
      else b = 1'b1;
      step(en, s, b);
    end
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b1);
    if (auto_ack) begin
      for (int k = 0; k < N; k++)
        chk(expq[k].size() == 0, tag, expq[k].size(), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20231));
    rst_n = 1'b0;
    rx_en = 1'b0;
    slot_idx = '0;
    rx_bit = 1'b1;
    node_addr = SELF;
    rd_ack = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rx_valid == '0, "R1 valid after reset", rx_valid, 0);
    chk(rx_ovf == '0, "R1 ovf after reset", rx_ovf, 0);
    chk(rx_data == '0, "R1 data after reset", rx_data, 0);

    // R2 + R4: leading idle ones, then a frame for this node
    queue_frame(1, SELF, 8'hA5, 8'h3C, 6);
    run_streams(1'b0, "R2 R4 frame to own address delivered");

    // R5: broadcast destination
    queue_frame(2, 8'hFF, 8'h81, 8'h7E, 0);
    run_streams(1'b0, "R5 broadcast frame delivered");

    // R6: foreign frame discarded, lane then accepts the next one
    queue_frame(3, 8'h33, 8'hDE, 8'hAD, 1);
    queue_frame(3, SELF, 8'h12, 8'h34, 2);
    run_streams(1'b0, "R6 foreign frame skipped then next accepted");

    // R9: a full frame strobed on the own slot changes nothing
    queue_frame(OWN, SELF, 8'hC3, 8'h99, 0);
    expq[OWN].delete();
    while (sq[OWN].size() != 0) step(1'b1, OWN, sq[OWN].pop_front());
    step(1'b0, 0, 1'b1);
    @(negedge clk);
    chk(rx_valid == '0, "R9 own slot valid", rx_valid, 0);
    chk(rx_data == '0 || rx_data[7:0] == 8'h00, "R9 own slot data", rx_data[7:0], 0);

    // R8 + R7: no reads between two payload bytes
    auto_ack = 1'b0;
    man_ack  = '0;
    queue_frame(1, SELF, 8'h11, 8'h22, 0);
    expq[1].delete();
    run_streams(1'b0, "R8");
    @(negedge clk);
    chk(rx_valid[1] == 1'b1, "R8 byte still held", rx_valid[1], 1);
    chk(rx_ovf[1] == 1'b1, "R8 overflow flagged", rx_ovf[1], 1);
    chk(rx_data[15:8] == 8'h11, "R8 old byte kept", rx_data[15:8], 8'h11);
    man_ack = 4'b0010;
    step(1'b0, 0, 1'b1);
    man_ack = '0;
    step(1'b0, 0, 1'b1);
    @(negedge clk);
    chk(rx_valid[1] == 1'b0, "R7 ack clears valid", rx_valid[1], 0);
    chk(rx_ovf[1] == 1'b0, "R7 ack clears overflow", rx_ovf[1], 0);
    auto_ack = 1'b1;

    // R3: random interleaving of all remote sources
    for (int r = 0; r < 40; r++) begin
      for (int s = 1; s < N; s++) begin
        int kind;
        logic [7:0] d;
        kind = $urandom_range(0, 2);
        if (kind == 0) d = SELF;
        else if (kind == 1) d = 8'hFF;
        else begin
          d = 8'($urandom);
          if (d == SELF || d == 8'hFF) d = 8'h00;
        end
        queue_frame(s, d, 8'($urandom), 8'($urandom), $urandom_range(0, 4));
      end
      run_streams(1'b1, "R3 interleaved sources all delivered");
    end

    summary();
    $finish;
  end
endmodule